// File: doc/BRIEF.md
# Program Memory Table Access Unit

This unit moves data between an 8-bit register file and a 16-bit-wide program memory. It holds a 16-bit table pointer and a 16-bit table latch that is addressed one byte at a time. A table instruction names a register, selects the high or low byte of the latch, and says whether the pointer advances after the access. A table write first places the register byte into the selected half of the latch, then sends the whole latch word to program memory at the pointer address. A table read first hands the selected latch byte to the register, then refills the latch from program memory at the pointer address.

Each instruction cycle is modelled as one clock. The cycle in which the instruction is issued does the decode, the register read and the latch-byte or register update. The second cycle drives the pointer onto the memory address bus with the proper strobe. A pointer below a parameterised boundary targets internal programmable memory. A write there holds a programming strobe for a parameterised number of cycles. That write ends early when an interrupt request arrives. It shrinks to a plain two-cycle access that writes nothing when the programming voltage is absent. While an instruction is in flight, `busy` stalls the pipeline. `done` marks the cycle in which the instruction completes. The pointer can be loaded by the core while the unit is idle. Table instructions do not touch any status flags.

Top module: `tblx_unit`

## Requirements
- R1: An instruction word with bits [15:10] = 101011 is a table write and 101010 is a table read; bit 9 is the byte select (1 = high byte), bit 8 the post-increment flag and bits [7:0] the register address driven on `reg_addr`. Any other bits [15:10] value is ignored: no register write, `busy` stays low, and pointer and latch keep their values.
- R2: In the issue cycle of a table write, `reg_rdata` is stored into the latch high byte when bit 9 is 1 and into the low byte when it is 0; the other byte is unchanged.
- R3: In the issue cycle of a table read, `reg_we` is high and `reg_wdata` equals the latch high byte (bit 9 = 1) or low byte (bit 9 = 0) as it was before the instruction.
- R4: In the cycle after a table read is issued, `pm_rd` is high with `pm_addr` equal to the pointer, and the latch then holds the `pm_rdata` word sampled in that cycle.
- R5: When bit 8 is 1 the pointer increases by one at completion, wrapping from 0xFFFF to 0x0000; when it is 0 the pointer is unchanged.
- R6: A table write with the pointer at or above `INT_LIMIT` lasts two cycles: in the second, `pm_wr_n` is low, `pm_addr` is the pointer, `pm_wdata` is the latch including the byte just stored, and `done` is high.
- R7: A table write with the pointer below `INT_LIMIT` and `pgm_ok` high holds `prog_en` and `busy` high for `PROG_CYCLES` cycles after the issue cycle, with `done` in the last of them.
- R8: An `irq` during an internal programming write ends it in that cycle with `done` high; `prog_en` is low in the next cycle, and the pointer is still post-incremented when bit 8 is 1.
- R9: A table write with the pointer below `INT_LIMIT` and `pgm_ok` low lasts two cycles with `done` in the second, and neither `pm_wr_n` nor `prog_en` is asserted.
- R10: While `busy` is high, `start` and `ptr_wr` are ignored: no register write occurs and the pointer keeps its value.
- R11: During and after reset the pointer and the latch are 0x0000, `busy`, `done`, `pm_rd` and `prog_en` are low and `pm_wr_n` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one edge per instruction cycle |
| arst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Issue the instruction on `instr` this cycle |
| instr | input | 16 | Instruction word |
| reg_addr | output | 8 | Register file address from the instruction |
| reg_rdata | input | 8 | Register file read data at `reg_addr` |
| reg_we | output | 1 | Register file write enable (table read) |
| reg_wdata | output | 8 | Register file write data (selected latch byte) |
| ptr_wr | input | 1 | Load the table pointer (idle only) |
| ptr_wdata | input | 16 | Pointer load value |
| pm_addr | output | 16 | Program memory address (table pointer) |
| pm_wdata | output | 16 | Program memory write data (table latch) |
| pm_rdata | input | 16 | Program memory read data |
| pm_rd | output | 1 | Program memory read strobe |
| pm_wr_n | output | 1 | External program memory write strobe, active low |
| prog_en | output | 1 | Internal memory programming strobe |
| pgm_ok | input | 1 | Programming voltage present |
| irq | input | 1 | Interrupt request |
| busy | output | 1 | Instruction in progress, stall the pipeline |
| done | output | 1 | Instruction completes this cycle |

## Verification
The hardest situation to reach is the interrupt that lands in the middle of an internal programming write. It needs the pointer below the boundary, the programming voltage present and the interrupt timed to a chosen cycle of the long write. The stimulus loads the pointer, issues the write, and raises `irq` in exactly the third busy cycle. It then checks that the instruction ends there and that the pointer still advances. The wrap from 0xFFFF is reached by loading the pointer and issuing one incrementing read. Issue attempts and pointer loads are also driven during a busy cycle.

// File: rtl/tblx_pkg.sv
package tblx_pkg;

  localparam logic [5:0] OPC_TRD = 6'b101010;
  localparam logic [5:0] OPC_TWR = 6'b101011;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } tbl_op_e;

  typedef struct packed {
    tbl_op_e    op;
    logic       hi;
    logic       inc;
    logic [7:0] fa;
  } tbl_dec_s;

  typedef enum logic {
    S_IDLE = 1'b0,
    S_MEM  = 1'b1
  } tbl_st_e;

endpackage

// File: rtl/tblx_rstsync.sv
module tblx_rstsync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n = sync_q[1];

endmodule

// File: rtl/tblx_decode.sv
module tblx_decode
  import tblx_pkg::*;
(
  input  logic [15:0] instr,
  output tbl_dec_s    dec
);

  always_comb begin
    dec.hi  = instr[9];
    dec.inc = instr[8];
    dec.fa  = instr[7:0];
    unique case (instr[15:10])
      OPC_TRD: dec.op = OP_RD;
      OPC_TWR: dec.op = OP_WR;
      default: dec.op = OP_NONE;
    endcase
  end

endmodule

// File: rtl/tblx_regs.sv
module tblx_regs #(
  parameter int AW = 16,
  parameter int DW = 8,
  localparam int NB = 2,
  localparam int LW = NB * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ptr_ld,
  input  logic [AW-1:0] ptr_ld_val,
  input  logic          ptr_inc,
  input  logic          byte_we,
  input  logic          hi_sel,
  input  logic [DW-1:0] byte_in,
  input  logic          word_we,
  input  logic [LW-1:0] word_in,
  output logic [AW-1:0] ptr,
  output logic [LW-1:0] lat
);

  logic [AW-1:0] ptr_q, ptr_nx;
  logic          ptr_en;

  always_comb begin
    ptr_en = ptr_ld | ptr_inc;
    ptr_nx = ptr_q;
    if (ptr_ld)       ptr_nx = ptr_ld_val;
    else if (ptr_inc) ptr_nx = ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_nx;
  end

  assign ptr = ptr_q;

  for (genvar g = 0; g < NB; g++) begin : g_lbyte
    logic [DW-1:0] b_q, b_nx;
    logic          b_en;
    logic          b_sel;

    assign b_sel = (hi_sel == (g == NB - 1));

    always_comb begin
      b_en = word_we | (byte_we & b_sel);
      b_nx = word_we ? word_in[g*DW +: DW] : byte_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    b_q <= '0;
      else if (b_en) b_q <= b_nx;
    end

    assign lat[g*DW +: DW] = b_q;
  end

  // R5: increment adds exactly one, modulo the pointer width
  a_r5_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_inc && !ptr_ld) |=> (ptr == $past(ptr) + 1'b1));

  // R5 / R10: with no load and no increment the pointer holds
  a_r5_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ptr_inc && !ptr_ld) |=> $stable(ptr));

  // R2: a high-byte store leaves the low byte alone
  a_r2_low_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_we && hi_sel && !word_we) |=> (lat[DW-1:0] == $past(lat[DW-1:0])));

  // R2: a low-byte store leaves the high byte alone
  a_r2_high_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_we && !hi_sel && !word_we) |=> (lat[LW-1:DW] == $past(lat[LW-1:DW])));

endmodule

// File: rtl/tblx_seq.sv
module tblx_seq
  import tblx_pkg::*;
#(
  parameter int PROG_CYCLES = 6,
  localparam int CW = (PROG_CYCLES > 2) ? $clog2(PROG_CYCLES) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic is_rd,
  input  logic is_wr,
  input  logic inc,
  input  logic internal,
  input  logic pgm_ok,
  input  logic irq,
  output logic busy,
  output logic done,
  output logic rd_stb,
  output logic wr_stb,
  output logic prog_stb,
  output logic ptr_inc,
  output logic word_we
);

  localparam logic [CW-1:0] LAST = CW'(PROG_CYCLES - 1);

  tbl_st_e       st_q, st_nx;
  logic [CW-1:0] cnt_q, cnt_nx;
  logic          rd_q, wr_q, inc_q, long_q, ext_q;
  logic          rd_nx, wr_nx, inc_nx, long_nx, ext_nx;
  logic          fin;
  logic          cnt_en, op_en;

  always_comb begin
    busy     = (st_q == S_MEM);
    fin      = busy & (~long_q | (cnt_q == LAST) | irq);
    done     = fin;
    rd_stb   = busy & rd_q;
    wr_stb   = busy & wr_q & ext_q;
    prog_stb = busy & long_q;
    ptr_inc  = fin & inc_q;
    word_we  = fin & rd_q;
  end

  always_comb begin
    st_nx   = st_q;
    cnt_nx  = cnt_q;
    cnt_en  = 1'b0;
    op_en   = 1'b0;
    rd_nx   = is_rd;
    wr_nx   = is_wr;
    inc_nx  = inc;
    long_nx = is_wr & internal & pgm_ok;
    ext_nx  = ~internal;
    unique case (st_q)
      S_IDLE: begin
        if (go) begin
          st_nx  = S_MEM;
          cnt_nx = '0;
          cnt_en = 1'b1;
          op_en  = 1'b1;
        end
      end
      S_MEM: begin
        if (fin) begin
          st_nx = S_IDLE;
        end else begin
          cnt_nx = cnt_q + 1'b1;
          cnt_en = 1'b1;
        end
      end
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= S_IDLE;
    else        st_q <= st_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= 1'b0;
      wr_q   <= 1'b0;
      inc_q  <= 1'b0;
      long_q <= 1'b0;
      ext_q  <= 1'b0;
    end else if (op_en) begin
      rd_q   <= rd_nx;
      wr_q   <= wr_nx;
      inc_q  <= inc_nx;
      long_q <= long_nx;
      ext_q  <= ext_nx;
    end
  end

  // R8: an interrupt during programming ends the instruction at once
  a_r8_irq_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_stb && irq) |=> (!busy && !prog_stb));

  // R7: programming continues until the count is reached
  a_r7_keeps_going: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_stb && !irq && (cnt_q != LAST)) |=> (busy && prog_stb));

  // R10: completion returns to idle, so a new instruction needs a new issue
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  // R6 / R9: short accesses take a single busy cycle
  a_r9_short_one: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && go && !(is_wr && internal && pgm_ok)) |=> (busy && done));

endmodule

// File: rtl/tblx_unit.sv
module tblx_unit
  import tblx_pkg::*;
#(
  parameter int              AW          = 16,
  parameter int              DW          = 8,
  parameter int              PROG_CYCLES = 6,
  parameter logic [AW-1:0]   INT_LIMIT   = 16'h2000,
  localparam int             LW          = 2 * DW
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          start,
  input  logic [15:0]   instr,
  output logic [7:0]    reg_addr,
  input  logic [DW-1:0] reg_rdata,
  output logic          reg_we,
  output logic [DW-1:0] reg_wdata,
  input  logic          ptr_wr,
  input  logic [AW-1:0] ptr_wdata,
  output logic [AW-1:0] pm_addr,
  output logic [LW-1:0] pm_wdata,
  input  logic [LW-1:0] pm_rdata,
  output logic          pm_rd,
  output logic          pm_wr_n,
  output logic          prog_en,
  input  logic          pgm_ok,
  input  logic          irq,
  output logic          busy,
  output logic          done
);

  logic          rst_n;
  tbl_dec_s      dec;
  logic          go, is_rd, is_wr, internal;
  logic          ptr_ld, ptr_inc, word_we, byte_we, wr_stb;
  logic [AW-1:0] ptr;
  logic [LW-1:0] lat;

  tblx_rstsync u_rst (
    .clk    (clk),
    .arst_n (arst_n),
    .rst_n  (rst_n)
  );

  tblx_decode u_dec (
    .instr (instr),
    .dec   (dec)
  );

  always_comb begin
    is_rd     = (dec.op == OP_RD);
    is_wr     = (dec.op == OP_WR);
    go        = start & ~busy & (is_rd | is_wr);
    internal  = (ptr < INT_LIMIT);
    reg_addr  = dec.fa;
    reg_we    = go & is_rd;
    reg_wdata = dec.hi ? lat[LW-1:DW] : lat[DW-1:0];
    byte_we   = go & is_wr;
    ptr_ld    = ptr_wr & ~busy & ~go;
    pm_addr   = ptr;
    pm_wdata  = lat;
    pm_wr_n   = ~wr_stb;
  end

  tblx_regs #(
    .AW (AW),
    .DW (DW)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .ptr_ld     (ptr_ld),
    .ptr_ld_val (ptr_wdata),
    .ptr_inc    (ptr_inc),
    .byte_we    (byte_we),
    .hi_sel     (dec.hi),
    .byte_in    (reg_rdata),
    .word_we    (word_we),
    .word_in    (pm_rdata),
    .ptr        (ptr),
    .lat        (lat)
  );

  tblx_seq #(
    .PROG_CYCLES (PROG_CYCLES)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (go),
    .is_rd    (is_rd),
    .is_wr    (is_wr),
    .inc      (dec.inc),
    .internal (internal),
    .pgm_ok   (pgm_ok),
    .irq      (irq),
    .busy     (busy),
    .done     (done),
    .rd_stb   (pm_rd),
    .wr_stb   (wr_stb),
    .prog_stb (prog_en),
    .ptr_inc  (ptr_inc),
    .word_we  (word_we)
  );

  // R10: no register write while an instruction is in flight
  a_r10_no_we_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !reg_we);

  // R4 / R6 / R7: at most one memory strobe at a time
  a_r6_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pm_rd, !pm_wr_n, prog_en}));

  // R4: a completed read leaves the sampled memory word in the latch
  a_r4_latch_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (done && pm_rd) |=> (pm_wdata == $past(pm_rdata)));

  // R9: no write strobe at all for an internal target
  a_r9_no_ext_wr: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && internal) |-> pm_wr_n);

endmodule

// File: tb/tblx_unit_test.sv
module tblx_unit_test;

  localparam int          CLK_PERIOD  = 10;
  localparam int          PROG_CYCLES = 6;
  localparam logic [15:0] INT_LIMIT   = 16'h2000;

  logic        clk = 1'b0;
  logic        arst_n;
  logic        start, ptr_wr, pgm_ok, irq;
  logic [15:0] instr, ptr_wdata;
  logic [7:0]  reg_addr, reg_rdata, reg_wdata;
  logic        reg_we;
  logic [15:0] pm_addr, pm_wdata, pm_rdata;
  logic        pm_rd, pm_wr_n, prog_en, busy, done;

  int n_chk  = 0;
  int n_fail = 0;
  bit mon_on = 1'b0;
  bit ended  = 1'b0;

  logic [7:0]  q_reg[$];
  string       q_reg_tag[$];
  logic [18:0] q_done[$];
  string       q_done_tag[$];

  logic [15:0] m_ptr, m_lat;

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [7:0] regval(input logic [7:0] a);
    return a ^ 8'h5A;
  endfunction

  function automatic logic [15:0] memval(input logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'h3C96;
  endfunction

  assign reg_rdata = regval(reg_addr);
  assign pm_rdata  = memval(pm_addr);

  tblx_unit #(
    .PROG_CYCLES (PROG_CYCLES),
    .INT_LIMIT   (INT_LIMIT)
  ) uut (
    .clk       (clk),
    .arst_n    (arst_n),
    .start     (start),
    .instr     (instr),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .ptr_wr    (ptr_wr),
    .ptr_wdata (ptr_wdata),
    .pm_addr   (pm_addr),
    .pm_wdata  (pm_wdata),
    .pm_rdata  (pm_rdata),
    .pm_rd     (pm_rd),
    .pm_wr_n   (pm_wr_n),
    .prog_en   (prog_en),
    .pgm_ok    (pgm_ok),
    .irq       (irq),
    .busy      (busy),
    .done      (done)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected items as the design produces them
  always @(negedge clk) begin
    if (mon_on) begin
      if (reg_we) begin
        if (q_reg.size() == 0) begin
          chk(1'b0, "R10 unexpected reg write", {24'h0, reg_wdata}, 32'h0);
        end else begin
          logic [7:0] e;
          string      t;
          e = q_reg.pop_front();
          t = q_reg_tag.pop_front();
          chk(reg_wdata == e, t, {24'h0, reg_wdata}, {24'h0, e});
        end
      end
      if (done) begin
        if (q_done.size() == 0) begin
          chk(1'b0, "R1 unexpected done", {16'h0, pm_addr}, 32'h0);
        end else begin
          logic [18:0] e;
          string       t;
          e = q_done.pop_front();
          t = q_done_tag.pop_front();
          chk({pm_addr, pm_rd, pm_wr_n, prog_en} == e, t,
              {13'h0, pm_addr, pm_rd, pm_wr_n, prog_en}, {13'h0, e});
        end
      end
    end
  end

  task automatic set_ptr(input logic [15:0] v);
    @(posedge clk); #1;
    ptr_wr = 1'b1; ptr_wdata = v;
    @(posedge clk); #1;
    ptr_wr = 1'b0;
    m_ptr = v;
  endtask

  // driver: predicts results, queues them, then issues the instruction
  task automatic run(input logic [15:0] ins, input int irq_at, input string tag);
    logic       t, i, intl;
    logic [7:0] f;
    int         exp_busy, k;
    t = ins[9]; i = ins[8]; f = ins[7:0];
    intl = (m_ptr < INT_LIMIT);
    exp_busy = 0;
    if (ins[15:10] == 6'b101010) begin
      q_reg.push_back(t ? m_lat[15:8] : m_lat[7:0]);
      q_reg_tag.push_back({"R3 ", tag});
      q_done.push_back({m_ptr, 1'b1, 1'b1, 1'b0});
      q_done_tag.push_back({"R4 ", tag});
      m_lat = memval(m_ptr);
      exp_busy = 1;
    end else if (ins[15:10] == 6'b101011) begin
      if (t) m_lat[15:8] = regval(f);
      else   m_lat[7:0]  = regval(f);
      if (!intl) begin
        q_done.push_back({m_ptr, 1'b0, 1'b0, 1'b0});
        q_done_tag.push_back({"R6 ", tag});
        exp_busy = 1;
      end else if (pgm_ok) begin
        q_done.push_back({m_ptr, 1'b0, 1'b1, 1'b1});
        q_done_tag.push_back({"R7 ", tag});
        exp_busy = (irq_at != 0) ? irq_at : PROG_CYCLES;
      end else begin
        q_done.push_back({m_ptr, 1'b0, 1'b1, 1'b0});
        q_done_tag.push_back({"R9 ", tag});
        exp_busy = 1;
      end
    end
    if (exp_busy != 0 && i) m_ptr = m_ptr + 16'd1;

    @(posedge clk); #1;
    start = 1'b1; instr = ins;
    k = 1;
    forever begin
      @(posedge clk); #1;
      start = 1'b0;
      irq = (k == irq_at);
      @(negedge clk);
      if (!busy) break;
      k++;
    end
    irq = 1'b0;
    chk((k - 1) == exp_busy, {"R7 busy length ", tag}, k - 1, exp_busy);
    chk(pm_addr == m_ptr, {"R5 pointer ", tag}, {16'h0, pm_addr}, {16'h0, m_ptr});
    chk(pm_wdata == m_lat, {"R2 latch ", tag}, {16'h0, pm_wdata}, {16'h0, m_lat});
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!ended) begin
      ended = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    arst_n = 1'b0; start = 1'b0; instr = 16'h0; ptr_wr = 1'b0;
    ptr_wdata = 16'h0; pgm_ok = 1'b1; irq = 1'b0;
    m_ptr = 16'h0; m_lat = 16'h0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(!busy && !done && !pm_rd && pm_wr_n && !prog_en, "R11 strobes in reset",
        {27'h0, busy, done, pm_rd, pm_wr_n, prog_en}, 32'h2);
    chk(pm_addr == 16'h0 && pm_wdata == 16'h0, "R11 pointer and latch in reset",
        {pm_addr, pm_wdata}, 32'h0);
    @(posedge clk); #1;
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && pm_addr == 16'h0, "R11 after release", {15'h0, busy, pm_addr}, 32'h0);
    mon_on = 1'b1;

    // external writes, both bytes, with and without increment (R2, R6, R5)
    set_ptr(16'hA356);
    run(16'hAE10, 0, "ext write high no inc");
    run(16'hAD0F, 0, "ext write low inc");
    // reads (R3, R4, R5)
    run(16'hAB20, 0, "read high inc");
    run(16'hA821, 0, "read low no inc");
    // R5: wrap from 0xFFFF
    set_ptr(16'hFFFF);
    run(16'hA930, 0, "read wrap");
    chk(pm_addr == 16'h0000, "R5 wrap to zero", {16'h0, pm_addr}, 32'h0);
    // R7: full internal programming write
    run(16'hAD33, 0, "internal long write");
    // R8: interrupt in third busy cycle
    run(16'hAF44, 3, "internal write abort");
    chk(!prog_en, "R8 strobe low after abort", {31'h0, prog_en}, 32'h0);
    // R9: no programming voltage
    pgm_ok = 1'b0;
    run(16'hAC01, 0, "short write");
    pgm_ok = 1'b1;
    // R1: illegal opcode ignored
    run(16'hB3FF, 0, "R1 illegal code");

    // R10: issue and pointer load during busy are ignored
    set_ptr(16'h3000);
    m_lat[15:8] = regval(8'h77);
    q_done.push_back({16'h3000, 1'b0, 1'b0, 1'b0});
    q_done_tag.push_back("R6 write before busy probe");
    @(posedge clk); #1;
    start = 1'b1; instr = 16'hAE77;
    @(posedge clk); #1;
    instr = 16'hAB00; ptr_wr = 1'b1; ptr_wdata = 16'h1111;
    @(negedge clk);
    chk(busy && !reg_we, "R10 issue ignored while busy", {30'h0, busy, reg_we}, 32'h2);
    @(posedge clk); #1;
    start = 1'b0; ptr_wr = 1'b0;
    @(negedge clk);
    chk(pm_addr == 16'h3000, "R10 pointer load ignored", {16'h0, pm_addr}, 32'h3000);
    chk(pm_wdata == m_lat, "R10 latch after probe", {16'h0, pm_wdata}, {16'h0, m_lat});

    repeat (2) @(negedge clk);
    chk(q_reg.size() == 0 && q_done.size() == 0, "R3 all expected items seen",
        q_reg.size() + q_done.size(), 32'h0);
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule